// File: doc/BRIEF.md
# Windowed Display RAM Address Generator

This block keeps the column and row pointers a host uses to stream pixel data into a display RAM of 64 byte-wide columns by 128 rows, where each byte holds two 4-bit pixels. The host first programs a rectangular window by giving a start and an end for each axis. Every data access then moves the pointers one step through that window. When a pointer reaches the end of its axis, it returns to that axis's start. This lets a host fill any sub-rectangle with one uninterrupted burst.

A three-bit remap input sets the traversal order and the data layout. One bit chooses between row-major order (horizontal) and column-major order (vertical). A second bit exchanges the two pixel nibbles of the write data. A third bit mirrors the column index, so that segments run right to left. The block outputs the RAM address for the current pointer pair and the remapped write byte. The RAM array sits outside the block.

Top module: `winAddrGen`

## Requirements
- R1: After reset, the column window is 0 to NCOLS-1 and the row window is 0 to NROWS-1, and both pointers are 0. With the default 64 by 128 size this gives `ramAddr` = 0.
- R2: When remapBits[2] = 0 (horizontal), an access adds 1 to the column pointer. If the column pointer equals the column end, it returns to the column start and the row pointer advances. The row pointer returns to the row start if it was at the row end.
- R3: When remapBits[2] = 1 (vertical), an access adds 1 to the row pointer. If the row pointer equals the row end, it returns to the row start and the column pointer advances. The column pointer returns to the column start if it was at the column end.
- R4: The traversal order is taken from remapBits[2] in the cycle of each access. Changing remapBits[2] alone never moves a pointer.
- R5: A column load stores the new column start and end and sets the column pointer to the new start. The row pointer is left as it is. A row load does the same on the row axis.
- R6: When remapBits[0] = 1, the column part of the address is NCOLS-1 minus the column pointer.
- R7: When remapBits[1] = 1, `wrDataOut` is `wrDataIn` with its upper and lower nibbles exchanged. Otherwise `wrDataOut` equals `wrDataIn`.
- R8: `ramAddr` = row pointer × NCOLS + physical column, and it is valid in the same cycle as the pointers.
- R9: In a cycle with no access and no load, neither pointer changes.
- R10: In a cycle with any load, the access strobe is ignored. Neither pointer steps, and only the loaded axis takes its new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| colLoad | input | 1 | Strobe that stores the column window and resets the column pointer |
| colStartIn | input | COL_W | New column start |
| colEndIn | input | COL_W | New column end |
| rowLoad | input | 1 | Strobe that stores the row window and resets the row pointer |
| rowStartIn | input | ROW_W | New row start |
| rowEndIn | input | ROW_W | New row end |
| remapBits | input | 3 | Bit 0: column mirror; bit 1: nibble swap; bit 2: vertical order |
| accessStb | input | 1 | One RAM access; advances the pointers |
| wrDataIn | input | DATA_W | Write data from the host |
| ramAddr | output | ROW_W+COL_W | RAM address for the current pointers |
| wrDataOut | output | DATA_W | Remapped write data |

## Verification
The bench builds the block with COL_W = 3 and ROW_W = 3, which gives an 8 by 8 array. At that size the bench can walk every one of the 36 × 36 window pairs in both traversal orders. Each walk runs past the window's last cell, so every wrap on both axes is reached, and the mirror setting alternates across windows. The 8-bit data path is small enough to test all 256 write bytes with the swap off and with it on. Directed sequences cover a single-axis reload in the middle of a burst, a load that arrives together with an access, and idle cycles.

// File: rtl/winAddrPkg.sv
package winAddrPkg;

  // Per-cycle pointer actions from control to datapath
  typedef struct packed {
    logic colLoad;
    logic colInc;
    logic colWrap;
    logic rowLoad;
    logic rowInc;
    logic rowWrap;
  } ptrStrobeT;

  // Positions inside the remap input
  localparam int unsigned REMAP_MIRROR = 0;
  localparam int unsigned REMAP_SWAP   = 1;
  localparam int unsigned REMAP_VERT   = 2;

endpackage

// File: rtl/winAddrCtrl.sv
module winAddrCtrl
  import winAddrPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      accessStb,
  input  logic      colLoadReq,
  input  logic      rowLoadReq,
  input  logic      vertMode,
  input  logic      colAtEnd,
  input  logic      rowAtEnd,
  output ptrStrobeT stb
);

  logic stepOk;

  assign stepOk = accessStb && !colLoadReq && !rowLoadReq;

  always_comb begin
    stb         = '0;
    stb.colLoad = colLoadReq;
    stb.rowLoad = rowLoadReq;
    if (stepOk) begin
      if (!vertMode) begin
        // row-major: column is the fast axis
        if (colAtEnd) begin
          stb.colWrap = 1'b1;
          if (rowAtEnd) stb.rowWrap = 1'b1;
          else          stb.rowInc  = 1'b1;
        end else begin
          stb.colInc = 1'b1;
        end
      end else begin
        // column-major: row is the fast axis
        if (rowAtEnd) begin
          stb.rowWrap = 1'b1;
          if (colAtEnd) stb.colWrap = 1'b1;
          else          stb.colInc  = 1'b1;
        end else begin
          stb.rowInc = 1'b1;
        end
      end
    end
  end

  // R10
  load_blocks_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (colLoadReq || rowLoadReq) |-> !(stb.colInc || stb.colWrap || stb.rowInc || stb.rowWrap));

  // R2
  horiz_fast_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepOk && !vertMode && !colAtEnd) |-> (stb.colInc && !stb.rowInc && !stb.rowWrap));

  // R3
  vert_fast_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepOk && vertMode && !rowAtEnd) |-> (stb.rowInc && !stb.colInc && !stb.colWrap));

  // R4
  one_col_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.colLoad, stb.colInc, stb.colWrap}) && $onehot0({stb.rowLoad, stb.rowInc, stb.rowWrap}));

endmodule

// File: rtl/winAddrPath.sv
module winAddrPath
  import winAddrPkg::*;
#(
  parameter int unsigned COL_W  = 6,
  parameter int unsigned ROW_W  = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ptrStrobeT              stb,
  input  logic [COL_W-1:0]       colStartIn,
  input  logic [COL_W-1:0]       colEndIn,
  input  logic [ROW_W-1:0]       rowStartIn,
  input  logic [ROW_W-1:0]       rowEndIn,
  input  logic                   mirrorEn,
  input  logic                   swapEn,
  input  logic [DATA_W-1:0]      wrDataIn,
  output logic                   colAtEnd,
  output logic                   rowAtEnd,
  output logic [ROW_W+COL_W-1:0] ramAddr,
  output logic [DATA_W-1:0]      wrDataOut
);

  localparam int unsigned NCOLS = 1 << COL_W;
  localparam int unsigned NROWS = 1 << ROW_W;
  localparam logic [COL_W-1:0] MAXCOL = COL_W'(NCOLS - 1);
  localparam logic [ROW_W-1:0] MAXROW = ROW_W'(NROWS - 1);
  localparam int unsigned HALF = DATA_W / 2;

  logic [COL_W-1:0] colStart, colEnd, colPtr, physCol;
  logic [ROW_W-1:0] rowStart, rowEnd, rowPtr;

  // column axis
  always_ff @(posedge clk) begin
    if (!rstN) begin
      colStart <= '0;
      colEnd   <= MAXCOL;
      colPtr   <= '0;
    end else if (stb.colLoad) begin
      colStart <= colStartIn;
      colEnd   <= colEndIn;
      colPtr   <= colStartIn;
    end else if (stb.colWrap) begin
      colPtr   <= colStart;
    end else if (stb.colInc) begin
      colPtr   <= colPtr + 1'b1;
    end
  end

  // row axis
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowStart <= '0;
      rowEnd   <= MAXROW;
      rowPtr   <= '0;
    end else if (stb.rowLoad) begin
      rowStart <= rowStartIn;
      rowEnd   <= rowEndIn;
      rowPtr   <= rowStartIn;
    end else if (stb.rowWrap) begin
      rowPtr   <= rowStart;
    end else if (stb.rowInc) begin
      rowPtr   <= rowPtr + 1'b1;
    end
  end

  assign colAtEnd = (colPtr == colEnd);
  assign rowAtEnd = (rowPtr == rowEnd);

  // mirrored column index, then row-major address
  assign physCol = mirrorEn ? (MAXCOL - colPtr) : colPtr;
  assign ramAddr = {rowPtr, physCol};

  // nibble exchange on the write path
  generate
    if (HALF > 0) begin : g_swap
      assign wrDataOut = swapEn ? {wrDataIn[HALF-1:0], wrDataIn[DATA_W-1:HALF]} : wrDataIn;
    end else begin : g_pass
      assign wrDataOut = wrDataIn;
    end
  endgenerate

  // R5
  col_load_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.colLoad |=> (colPtr == $past(colStartIn)));

  // R5
  row_load_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.rowLoad |=> (rowPtr == $past(rowStartIn)));

  // R2
  col_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.colInc |=> (colPtr == COL_W'($past(colPtr) + 1'b1)));

  // R3
  row_wrap_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.rowWrap |=> (rowPtr == rowStart));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb == '0) |=> ($stable(colPtr) && $stable(rowPtr)));

  // R6
  mirror_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    mirrorEn |-> (({1'b0, physCol} + {1'b0, colPtr}) == {1'b0, MAXCOL}));

  // R7
  swap_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(wrDataOut) == $countones(wrDataIn));

endmodule

// File: rtl/winAddrGen.sv
module winAddrGen
  import winAddrPkg::*;
#(
  parameter int unsigned COL_W  = 6,
  parameter int unsigned ROW_W  = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   colLoad,
  input  logic [COL_W-1:0]       colStartIn,
  input  logic [COL_W-1:0]       colEndIn,
  input  logic                   rowLoad,
  input  logic [ROW_W-1:0]       rowStartIn,
  input  logic [ROW_W-1:0]       rowEndIn,
  input  logic [2:0]             remapBits,
  input  logic                   accessStb,
  input  logic [DATA_W-1:0]      wrDataIn,
  output logic [ROW_W+COL_W-1:0] ramAddr,
  output logic [DATA_W-1:0]      wrDataOut
);

  ptrStrobeT stb;
  logic      colAtEnd, rowAtEnd;

  winAddrCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .accessStb  (accessStb),
    .colLoadReq (colLoad),
    .rowLoadReq (rowLoad),
    .vertMode   (remapBits[REMAP_VERT]),
    .colAtEnd   (colAtEnd),
    .rowAtEnd   (rowAtEnd),
    .stb        (stb)
  );

  winAddrPath #(
    .COL_W  (COL_W),
    .ROW_W  (ROW_W),
    .DATA_W (DATA_W)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .colStartIn (colStartIn),
    .colEndIn   (colEndIn),
    .rowStartIn (rowStartIn),
    .rowEndIn   (rowEndIn),
    .mirrorEn   (remapBits[REMAP_MIRROR]),
    .swapEn     (remapBits[REMAP_SWAP]),
    .wrDataIn   (wrDataIn),
    .colAtEnd   (colAtEnd),
    .rowAtEnd   (rowAtEnd),
    .ramAddr    (ramAddr),
    .wrDataOut  (wrDataOut)
  );

endmodule

// File: tb/tb_winAddrGen.sv
module tb_winAddrGen;

  localparam int CW = 3;
  localparam int RW = 3;
  localparam int DW = 8;
  localparam int NC = 1 << CW;
  localparam int NR = 1 << RW;

  logic          clk = 1'b0;
  logic          rstN;
  logic          colLoad, rowLoad, accessStb;
  logic [CW-1:0] colStartIn, colEndIn;
  logic [RW-1:0] rowStartIn, rowEndIn;
  logic [2:0]    remapBits;
  logic [DW-1:0] wrDataIn;
  logic [RW+CW-1:0] ramAddr;
  logic [DW-1:0] wrDataOut;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  winAddrGen #(.COL_W(CW), .ROW_W(RW), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .colLoad(colLoad), .colStartIn(colStartIn),
    .colEndIn(colEndIn), .rowLoad(rowLoad), .rowStartIn(rowStartIn),
    .rowEndIn(rowEndIn), .remapBits(remapBits), .accessStb(accessStb),
    .wrDataIn(wrDataIn), .ramAddr(ramAddr), .wrDataOut(wrDataOut)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic access();
    accessStb = 1'b1;
    @(posedge clk); @(negedge clk);
    accessStb = 1'b0;
  endtask

  task automatic loadBoth(input int cs, input int ce, input int rs, input int re);
    colLoad = 1'b1; rowLoad = 1'b1;
    colStartIn = CW'(cs); colEndIn = CW'(ce);
    rowStartIn = RW'(rs); rowEndIn = RW'(re);
    @(posedge clk); @(negedge clk);
    colLoad = 1'b0; rowLoad = 1'b0;
  endtask

  // expected address after k accesses into a freshly loaded window
  function automatic int expAddr(int cs, int ce, int rs, int re, int vert, int mir, int k);
    int w, h, m, c, r;
    w = ce - cs + 1;
    h = re - rs + 1;
    m = k % (w * h);
    if (vert == 0) begin
      c = cs + m % w;
      r = rs + m / w;
    end else begin
      r = rs + m % h;
      c = cs + m / h;
    end
    if (mir != 0) c = NC - 1 - c;
    return r * NC + c;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; colLoad = 0; rowLoad = 0; accessStb = 0;
    colStartIn = '0; colEndIn = '0; rowStartIn = '0; rowEndIn = '0;
    remapBits = 3'b000; wrDataIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset pointers and full-array window, walked row-major (R8)
    check("R1", ramAddr, 0);
    for (int k = 1; k <= NC * NR + 2; k++) begin
      access();
      check("R1", ramAddr, k % (NC * NR));
    end

    // R2 R3 R4 R6 R8: every window pair, both orders, mirror alternating
    for (int cs = 0; cs < NC; cs++)
      for (int ce = cs; ce < NC; ce++)
        for (int rs = 0; rs < NR; rs++)
          for (int re = rs; re < NR; re++)
            for (int vert = 0; vert < 2; vert++) begin
              int mir;
              int area;
              mir = (ce + re + vert) % 2;
              remapBits = {vert[0], 1'b0, mir[0]};
              loadBoth(cs, ce, rs, re);
              area = (ce - cs + 1) * (re - rs + 1);
              for (int k = 0; k <= area + 1; k++) begin
                if (k > 0) access();
                check(vert != 0 ? "R3" : "R2", ramAddr, expAddr(cs, ce, rs, re, vert, mir, k));
              end
              // R4: flipping the order bit alone moves nothing
              remapBits[2] = ~remapBits[2];
              @(posedge clk); @(negedge clk);
              check("R4", ramAddr, expAddr(cs, ce, rs, re, vert, mir, area + 1));
            end

    // R5: single-axis reload mid-burst, horizontal, no mirror
    remapBits = 3'b000;
    loadBoth(0, NC - 1, 0, NR - 1);
    for (int k = 0; k < 11; k++) access();
    check("R5", ramAddr, 1 * NC + 3);
    colLoad = 1'b1; colStartIn = 3'd5; colEndIn = 3'd6;
    @(posedge clk); @(negedge clk); colLoad = 1'b0;
    check("R5", ramAddr, 1 * NC + 5);
    access(); check("R2", ramAddr, 1 * NC + 6);
    access(); check("R2", ramAddr, 2 * NC + 5);
    rowLoad = 1'b1; rowStartIn = 3'd4; rowEndIn = 3'd4;
    @(posedge clk); @(negedge clk); rowLoad = 1'b0;
    check("R5", ramAddr, 4 * NC + 5);
    access(); check("R2", ramAddr, 4 * NC + 6);
    access(); check("R2", ramAddr, 4 * NC + 5);

    // R10: load together with an access; access is dropped
    colLoad = 1'b1; accessStb = 1'b1; colStartIn = 3'd2; colEndIn = 3'd3;
    @(posedge clk); @(negedge clk); colLoad = 1'b0; accessStb = 1'b0;
    check("R10", ramAddr, 4 * NC + 2);
    rowLoad = 1'b1; accessStb = 1'b1; rowStartIn = 3'd0; rowEndIn = 3'd7;
    @(posedge clk); @(negedge clk); rowLoad = 1'b0; accessStb = 1'b0;
    check("R10", ramAddr, 0 * NC + 2);

    // R9: idle cycles hold the pointers
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R9", ramAddr, 2);

    // R6: mirror applies to the output address only
    remapBits = 3'b001;
    #1 check("R6", ramAddr, NC - 1 - 2);
    remapBits = 3'b000;

    // R7: every data byte, swap off and on
    for (int s = 0; s < 2; s++)
      for (int v = 0; v < 256; v++) begin
        remapBits = {1'b0, s[0], 1'b0};
        wrDataIn = v[7:0];
        #1;
        check("R7", wrDataOut, s != 0 ? ((v % 16) * 16 + v / 16) : v);
      end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule